// File: doc/BRIEF.md
# Settable Time-of-Day Counter Chain

This block keeps the time of day for a 24-hour wall clock as three binary counters: seconds, minutes and hours. Everything runs on one system clock. Two single-cycle enables pace the counters. `sec_tick` arrives once per second. `set_tick` is a faster pulse, a few times per second, and is used only while the time is being set. Each counter raises a carry when it wraps, and that carry enables the next counter up the chain.

Two active-low push buttons set the time. Both buttons pass through a synchroniser before use. Holding either button clears the seconds and keeps them at zero.

- While the minute button is held, the minutes step on `set_tick` and the hours are frozen.
- While the hour button is held, the hours step on `set_tick`.

The seconds value goes out directly so it can drive LEDs. A one-cycle pulse marks each seconds rollover.

Top module: `tod_counter_chain`

## Requirements
- R1: `seconds` advances by one on each clock edge where `sec_tick` is 1 and no set button is in effect. It goes from 59 to 0 and never leaves the range 0 to 59.
- R2: `sec_wrap` is 1 only during a cycle where `sec_tick` is 1, `seconds` is 59 and no set button is in effect. On that edge `minutes` advances by one and `seconds` becomes 0.
- R3: `minutes` wraps from 59 to 0, and that wrap advances `hours` in normal running. `hours` stays in the range 0 to 23 and wraps from 23 to 0, so 23:59:59 plus one second gives 00:00:00.
- R4: While `rst_n` is low, all three counters read 0 and `sec_wrap` is 0.
- R5: While either set button is in effect, `seconds` is held at 0, `sec_tick` has no effect and `sec_wrap` stays 0.
- R6: While the minute button is in effect, `minutes` advances by one on each `set_tick` and wraps from 59 to 0. `sec_tick` does not change it.
- R7: While the minute button is in effect, `hours` does not change, even when `minutes` wraps.
- R8: While only the hour button is in effect, `hours` advances by one on each `set_tick` and wraps from 23 to 0. `minutes` does not change.
- R9: A button level passes through a two-flop synchroniser. A press applied before clock edge k first acts on edge k+2, so the seconds are cleared by that edge and not before. A release is delayed in the same way.
- R10: With both buttons held, `minutes` follows `set_tick` and `hours` stays frozen.
- R11: With no button held, `set_tick` changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sec_tick | input | 1 | One-cycle enable, once per second |
| set_tick | input | 1 | One-cycle enable at the fast setting rate |
| set_min_n | input | 1 | Minute-set button, active low, asynchronous |
| set_hr_n | input | 1 | Hour-set button, active low, asynchronous |
| seconds | output | 6 | Seconds, binary 0 to 59 |
| minutes | output | 6 | Minutes, binary 0 to 59 |
| hours | output | 5 | Hours, binary 0 to 23 |
| sec_wrap | output | 1 | One-cycle pulse on a seconds rollover |

## Verification
The bench uses plain `sec_tick` runs to show that the counters count and carry. It then carries the clock through the full-day rollover, which separates the minute carry from the hour wrap. It uses `set_tick` bursts under each button combination: none, minutes only, hours only, and both. These show which counter each button steers, that the hours stay frozen across a minute wrap, and that `set_tick` is ignored when no button is held. A press is sampled edge by edge to pin down the synchroniser delay. `sec_tick` pulses sent during a hold show that the seconds are held at zero.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_MOD = 60;
  localparam int MIN_MOD = 60;
  localparam int HR_MOD  = 24;
  localparam int SEC_W   = $clog2(SEC_MOD);
  localparam int MIN_W   = $clog2(MIN_MOD);
  localparam int HR_W    = $clog2(HR_MOD);
  localparam int NUM_BTN = 2;
  localparam int BTN_MIN = 0;
  localparam int BTN_HR  = 1;
endpackage

// File: rtl/tod_btn_sync.sv
module tod_btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic pressed
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = btn_n;
      end else begin : g_rest
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign pressed = ~stage_q[STAGES-1];
endmodule

// File: rtl/tod_mod_counter.sv
module tod_mod_counter #(
  parameter int MODULUS = 60,
  parameter int W       = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  logic [W-1:0] value_q;
  logic [W-1:0] value_d;
  logic         at_top;

  assign at_top = (value_q == TOP);
  assign wrap   = en && !clr && at_top;

  always_comb begin
    value_d = value_q;
    if (clr)         value_d = '0;
    else if (en) begin
      if (at_top)    value_d = '0;
      else           value_d = value_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value = value_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    value < W'(MODULUS)); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(value)); // R11
endmodule

// File: rtl/tod_set_ctrl.sv
module tod_set_ctrl (
  input  logic set_min,
  input  logic set_hr,
  input  logic sec_tick,
  input  logic set_tick,
  input  logic sec_carry,
  input  logic min_carry,
  output logic sec_clr,
  output logic sec_en,
  output logic min_en,
  output logic hr_en
);
  always_comb begin
    sec_clr = set_min || set_hr;
    sec_en  = sec_tick;
    if (set_min) min_en = set_tick;
    else         min_en = sec_carry;
    if (set_min)     hr_en = 1'b0;
    else if (set_hr) hr_en = set_tick;
    else             hr_en = min_carry;
  end
endmodule

// File: rtl/tod_counter_chain.sv
module tod_counter_chain
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             set_tick,
  input  logic             set_min_n,
  input  logic             set_hr_n,
  output logic [SEC_W-1:0] seconds,
  output logic [MIN_W-1:0] minutes,
  output logic [HR_W-1:0]  hours,
  output logic             sec_wrap
);
  logic [NUM_BTN-1:0] btn_raw_n;
  logic [NUM_BTN-1:0] btn_q;
  logic sec_clr, sec_en, min_en, hr_en;
  logic sec_carry, min_carry, hr_carry;

  assign btn_raw_n[BTN_MIN] = set_min_n;
  assign btn_raw_n[BTN_HR]  = set_hr_n;

  generate
    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      tod_btn_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (btn_raw_n[b]),
        .pressed (btn_q[b])
      );
    end
  endgenerate

  tod_set_ctrl i_ctrl (
    .set_min   (btn_q[BTN_MIN]),
    .set_hr    (btn_q[BTN_HR]),
    .sec_tick  (sec_tick),
    .set_tick  (set_tick),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .sec_clr   (sec_clr),
    .sec_en    (sec_en),
    .min_en    (min_en),
    .hr_en     (hr_en)
  );

  tod_mod_counter #(.MODULUS(SEC_MOD), .W(SEC_W)) i_sec (
    .clk (clk), .rst_n (rst_n), .clr (sec_clr), .en (sec_en),
    .value (seconds), .wrap (sec_carry)
  );

  tod_mod_counter #(.MODULUS(MIN_MOD), .W(MIN_W)) i_min (
    .clk (clk), .rst_n (rst_n), .clr (1'b0), .en (min_en),
    .value (minutes), .wrap (min_carry)
  );

  tod_mod_counter #(.MODULUS(HR_MOD), .W(HR_W)) i_hr (
    .clk (clk), .rst_n (rst_n), .clr (1'b0), .en (hr_en),
    .value (hours), .wrap (hr_carry)
  );

  assign sec_wrap = sec_carry;

  AST_WRAP_ADVANCES_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && minutes != MIN_W'(MIN_MOD-1)) |=> (minutes == $past(minutes) + MIN_W'(1))); // R2
  AST_SET_HOLDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_q != '0) |-> !sec_wrap); // R5
  AST_MIN_IGNORES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_q[BTN_MIN] && !set_tick) |=> $stable(minutes)); // R6
  AST_HOUR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    btn_q[BTN_MIN] |=> $stable(hours)); // R7
  AST_HR_SET_ONLY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_q[BTN_HR] && !set_tick) |=> $stable(hours)); // R8
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_carry && !btn_q[BTN_HR]) |=> (hours == '0 && minutes == '0)); // R3
endmodule

// File: tb/test_tod_counter_chain.sv
module test_tod_counter_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       set_tick = 1'b0;
  logic       set_min_n = 1'b1;
  logic       set_hr_n = 1'b1;
  logic [5:0] seconds;
  logic [5:0] minutes;
  logic [4:0] hours;
  logic       sec_wrap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tod_counter_chain i_tod_counter_chain (
    .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick), .set_tick (set_tick),
    .set_min_n (set_min_n), .set_hr_n (set_hr_n),
    .seconds (seconds), .minutes (minutes), .hours (hours), .sec_wrap (sec_wrap)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_time(input string tag, input int h, input int m, input int s);
    check({tag, " hours"}, int'(hours), h);
    check({tag, " minutes"}, int'(minutes), m);
    check({tag, " seconds"}, int'(seconds), s);
  endtask

  task automatic pulse_sec(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
    end
  endtask

  task automatic pulse_set(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) set_tick = 1'b1;
      @(negedge clk) set_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check_time("R4 reset", 0, 0, 0);
    check("R4 reset sec_wrap", int'(sec_wrap), 0);
  endtask

  task automatic t_seconds;
    pulse_sec(59);
    check_time("R1 count to 59", 0, 0, 59);
    @(negedge clk) sec_tick = 1'b1;
    #1 check("R2 sec_wrap during rollover", int'(sec_wrap), 1);
    @(negedge clk) sec_tick = 1'b0;
    #1 check("R2 sec_wrap single cycle", int'(sec_wrap), 0);
    check_time("R2 minute carry", 0, 1, 0);
  endtask

  task automatic t_idle_set_tick;
    pulse_sec(5);
    pulse_set(6);
    check_time("R11 set_tick ignored", 0, 1, 5);
  endtask

  task automatic t_sync_and_hour_set;
    @(negedge clk) set_hr_n = 1'b0;
    @(negedge clk);
    check("R9 one edge after press", int'(seconds), 5);
    @(negedge clk);
    check("R9 two edges after press", int'(seconds), 5);
    @(negedge clk);
    check("R9 R5 cleared on third edge", int'(seconds), 0);
    @(negedge clk) sec_tick = 1'b1;
    #1 check("R5 no sec_wrap while set", int'(sec_wrap), 0);
    @(negedge clk) sec_tick = 1'b0;
    pulse_sec(3);
    check("R5 seconds held", int'(seconds), 0);
    pulse_set(23);
    check_time("R8 hours set to 23", 23, 1, 0);
    pulse_set(1);
    check_time("R8 hours wrap 23 to 0", 0, 1, 0);
    pulse_set(23);
    check_time("R8 hours back to 23", 23, 1, 0);
    @(negedge clk) set_hr_n = 1'b1;
    idle(3);
  endtask

  task automatic t_minute_set;
    @(negedge clk) set_min_n = 1'b0;
    idle(3);
    pulse_set(58);
    check_time("R6 minutes via set_tick", 23, 59, 0);
    pulse_set(1);
    check_time("R7 minute wrap keeps hours", 23, 0, 0);
    pulse_sec(4);
    check_time("R6 sec_tick ignored", 23, 0, 0);
    pulse_set(59);
    check_time("R6 minutes to 59", 23, 59, 0);
    @(negedge clk) set_min_n = 1'b1;
    idle(3);
  endtask

  task automatic t_day_rollover;
    pulse_sec(59);
    check_time("R1 before day wrap", 23, 59, 59);
    @(negedge clk) sec_tick = 1'b1;
    #1 check("R2 sec_wrap at day wrap", int'(sec_wrap), 1);
    @(negedge clk) sec_tick = 1'b0;
    check_time("R3 day rollover", 0, 0, 0);
  endtask

  task automatic t_both_buttons;
    pulse_sec(7);
    @(negedge clk) begin set_min_n = 1'b0; set_hr_n = 1'b0; end
    idle(3);
    pulse_set(2);
    check_time("R10 both held", 0, 2, 0);
    @(negedge clk) begin set_min_n = 1'b1; set_hr_n = 1'b1; end
    idle(3);
  endtask

  task automatic t_reset_midrun;
    pulse_sec(9);
    @(negedge clk) rst_n = 1'b0;
    #1 check_time("R4 async reset", 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check_time("R4 after release", 0, 0, 0);
  endtask

  initial begin
    idle(3);
    t_reset;
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    t_reset;
    t_seconds;
    t_idle_set_tick;
    t_sync_and_hour_set;
    t_minute_set;
    t_day_rollover;
    t_both_buttons;
    t_reset_midrun;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule